// File: doc/BRIEF.md
# Variable-Length Instruction Stream Parser

This block accepts machine code one byte per cycle under a valid/ready handshake. The first byte of every instruction is its opcode, and the opcode alone sets whether the instruction is 2, 4 or 6 bytes long. The parser collects that many bytes and then holds one decoded record on its output until the consumer takes it.

The record carries a format tag (register-register, register-storage, register-indexed, storage-immediate, and two storage-storage layouts) with every field already split out. Operand lengths are stored in the instruction as length minus one, and the parser converts them back to true byte counts. Each register field whose zero value means "no register" (index, the RS third register, and base fields) has a flag that rises when that field is zero.

Top module: `insn_stream_parser`

## Requirements
- R1: The instruction length comes from opcode bits 7:6. The value 00 gives 2 bytes, 01 or 10 gives 4 bytes, and 11 gives 6 bytes. out_valid rises in the cycle after the last byte is accepted, and not after any earlier byte.
- R2: out_fmt encodes the layout as follows: RR=0, RS=1, RX=2, SI=3, SS1=4, SS2=5. RS is opcodes 0x80–0x8F and SI is 0x90–0x9F. RX is 0x40–0x7F and also 0xA0–0xBF. SS2 is 0xF0–0xFF and SS1 is 0xC0–0xEF. RR is 0x00–0x3F.
- R3: For RR, RS and RX, the high nibble of byte 2 appears on out_r1 and the low nibble on out_r2.
- R4: For RS, RX, SI, SS1 and SS2, the high nibble of byte 3 is out_base1. The low nibble of byte 3 is the top of the 12-bit out_disp1, and byte 4 is its low eight bits.
- R5: For SI, byte 2 appears unchanged on out_imm.
- R6: For SS1 and SS2, bytes 5–6 give out_base2 and out_disp2, using the same nibble split as R4.
- R7: For SS1, out_len1 is byte 2 plus one, covering 1 to 256, and out_len2 is 0.
- R8: For SS2, out_len1 is the high nibble of byte 2 plus one and out_len2 is the low nibble plus one, each covering 1 to 16.
- R9: out_r2_none is 1 only for RS or RX when out_r2 is 0. out_base1_none is 1 when a format with a first base field has that field at 0. out_base2_none works the same way for SS formats. For RR, a zero register never sets a flag.
- R10: Any record field that the format does not carry reads as zero.
- R11: While out_valid is high and out_ready is low, every record output holds steady and in_ready stays low. A record is removed on the edge where out_valid and out_ready are both high.
- R12: No byte is lost or duplicated across idle gaps on in_valid or across back-pressure.
- R13: After a synchronous reset, out_valid is 0 and in_ready is 1. Any partly collected instruction is discarded, so the next byte is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record |
| out_fmt | output | 3 | Format tag |
| out_opcode | output | 8 | Opcode byte |
| out_r1 | output | 4 | First register or mask |
| out_r2 | output | 4 | Second register, third register or index |
| out_r2_none | output | 1 | out_r2 is zero and means no register |
| out_imm | output | 8 | Immediate byte |
| out_base1 | output | 4 | First base register |
| out_base1_none | output | 1 | First base is zero and means none |
| out_disp1 | output | 12 | First displacement |
| out_base2 | output | 4 | Second base register |
| out_base2_none | output | 1 | Second base is zero and means none |
| out_disp2 | output | 12 | Second displacement |
| out_len1 | output | 9 | First operand length in bytes |
| out_len2 | output | 9 | Second operand length in bytes |

## Verification
The record is due exactly one cycle after the edge that accepts the final byte of an instruction. The bench samples out_valid at the falling edge before every accepted byte and expects it low, then expects it high at the falling edge right after the last byte. A record leaves on the first rising edge where out_ready is high, so out_valid is expected low at the next falling edge. During back-pressure, the bench checks in_ready and the held record once per cycle. It then keeps the pending byte driven through the consuming edge, and shows from the next decoded record that this byte was accepted exactly once.

// File: rtl/insn_parse_pkg.sv
package insn_parse_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 6;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int NUM_PAIRS = 2;
    localparam int REG_W     = 4;
    localparam int DISP_W    = 12;
    localparam int LEN_W     = BYTE_W + 1;

    typedef enum logic [2:0] {
        FMT_RR  = 3'd0,
        FMT_RS  = 3'd1,
        FMT_RX  = 3'd2,
        FMT_SI  = 3'd3,
        FMT_SS1 = 3'd4,
        FMT_SS2 = 3'd5
    } fmt_e;

    typedef logic [MAX_BYTES-1:0][BYTE_W-1:0] insn_bytes_t;

    typedef struct packed {
        fmt_e              fmt;
        logic [BYTE_W-1:0] opcode;
        logic [REG_W-1:0]  r1;
        logic [REG_W-1:0]  r2;
        logic              r2_none;
        logic [BYTE_W-1:0] imm;
        logic [REG_W-1:0]  base1;
        logic              base1_none;
        logic [DISP_W-1:0] disp1;
        logic [REG_W-1:0]  base2;
        logic              base2_none;
        logic [DISP_W-1:0] disp2;
        logic [LEN_W-1:0]  len1;
        logic [LEN_W-1:0]  len2;
    } insn_rec_t;

endpackage

// File: rtl/insn_len_class.sv
module insn_len_class
    import insn_parse_pkg::*;
(
    input  logic [1:0]       op_top,
    output logic [CNT_W-1:0] nbytes
);
    always_comb begin
        case (op_top)
            2'b00:   nbytes = CNT_W'(2);
            2'b11:   nbytes = CNT_W'(6);
            default: nbytes = CNT_W'(4);
        endcase
    end
endmodule

// File: rtl/insn_fmt_class.sv
module insn_fmt_class
    import insn_parse_pkg::*;
(
    input  logic [3:0] op_hi,
    output fmt_e       fmt
);
    always_comb begin
        case (op_hi[3:2])
            2'b00: fmt = FMT_RR;
            2'b01: fmt = FMT_RX;
            2'b10: begin
                if (op_hi[1])      fmt = FMT_RX;
                else if (op_hi[0]) fmt = FMT_SI;
                else               fmt = FMT_RS;
            end
            default: fmt = (op_hi == 4'hF) ? FMT_SS2 : FMT_SS1;
        endcase
    end
endmodule

// File: rtl/insn_byte_collect.sv
module insn_byte_collect
    import insn_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              rec_valid,
    input  logic              rec_ready,
    output insn_bytes_t       rec_bytes
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
        insn_bytes_t      bytes;
    } col_state_t;

    col_state_t        st_d, st_q;
    logic [BYTE_W-1:0] op_d;
    logic [CNT_W-1:0]  need_d;
    logic [CNT_W-1:0]  nxt_cnt_d;
    logic              take_d;

    assign op_d = (st_q.cnt == '0) ? in_byte : st_q.bytes[0];

    insn_len_class len_i (
        .op_top (op_d[7:6]),
        .nbytes (need_d)
    );

    always_comb begin
        st_d      = st_q;
        take_d    = in_valid && !st_q.full;
        nxt_cnt_d = st_q.cnt + CNT_W'(1);
        if (st_q.full && rec_ready) begin
            st_d.full = 1'b0;
        end
        if (take_d) begin
            if (st_q.cnt == '0) begin
                st_d.bytes = '0;
            end
            for (int i = 0; i < MAX_BYTES; i++) begin
                if (CNT_W'(i) == st_q.cnt) begin
                    st_d.bytes[i] = in_byte;
                end
            end
            if (nxt_cnt_d == need_d) begin
                st_d.full = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = nxt_cnt_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_ready  = !st_q.full;
    assign rec_valid = st_q.full;
    assign rec_bytes = st_q.bytes;

    // R1
    cnt_below_need_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < need_d);

    // R11
    pop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_ready |=> !rec_valid);

    // R12
    done_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.full) |-> st_q.cnt == '0);

endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
    import insn_parse_pkg::*;
(
    input  insn_bytes_t b,
    output insn_rec_t   rec
);
    fmt_e             fmt;
    logic [REG_W-1:0]  pb [NUM_PAIRS];
    logic [DISP_W-1:0] pd [NUM_PAIRS];

    insn_fmt_class fmt_i (
        .op_hi (b[0][7:4]),
        .fmt   (fmt)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign pb[p] = b[2 + 2*p][7:4];
        assign pd[p] = {b[2 + 2*p][3:0], b[3 + 2*p]};
    end

    always_comb begin
        rec        = '0;
        rec.fmt    = fmt;
        rec.opcode = b[0];
        if (fmt != FMT_RR) begin
            rec.base1      = pb[0];
            rec.base1_none = (pb[0] == '0);
            rec.disp1      = pd[0];
        end
        case (fmt)
            FMT_RR: begin
                rec.r1 = b[1][7:4];
                rec.r2 = b[1][3:0];
            end
            FMT_RS, FMT_RX: begin
                rec.r1      = b[1][7:4];
                rec.r2      = b[1][3:0];
                rec.r2_none = (b[1][3:0] == '0);
            end
            FMT_SI: begin
                rec.imm = b[1];
            end
            FMT_SS1, FMT_SS2: begin
                rec.base2      = pb[1];
                rec.base2_none = (pb[1] == '0);
                rec.disp2      = pd[1];
                if (fmt == FMT_SS1) begin
                    rec.len1 = LEN_W'(b[1]) + LEN_W'(1);
                end else begin
                    rec.len1 = LEN_W'(b[1][7:4]) + LEN_W'(1);
                    rec.len2 = LEN_W'(b[1][3:0]) + LEN_W'(1);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/insn_stream_parser.sv
module insn_stream_parser
    import insn_parse_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [7:0]   in_byte,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [2:0]   out_fmt,
    output logic [7:0]   out_opcode,
    output logic [3:0]   out_r1,
    output logic [3:0]   out_r2,
    output logic         out_r2_none,
    output logic [7:0]   out_imm,
    output logic [3:0]   out_base1,
    output logic         out_base1_none,
    output logic [11:0]  out_disp1,
    output logic [3:0]   out_base2,
    output logic         out_base2_none,
    output logic [11:0]  out_disp2,
    output logic [8:0]   out_len1,
    output logic [8:0]   out_len2
);
    insn_bytes_t held_bytes;
    insn_rec_t   rec;

    insn_byte_collect col_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_byte   (in_byte),
        .rec_valid (out_valid),
        .rec_ready (out_ready),
        .rec_bytes (held_bytes)
    );

    insn_field_split split_i (
        .b   (held_bytes),
        .rec (rec)
    );

    assign out_fmt        = rec.fmt;
    assign out_opcode     = rec.opcode;
    assign out_r1         = rec.r1;
    assign out_r2         = rec.r2;
    assign out_r2_none    = rec.r2_none;
    assign out_imm        = rec.imm;
    assign out_base1      = rec.base1;
    assign out_base1_none = rec.base1_none;
    assign out_disp1      = rec.disp1;
    assign out_base2      = rec.base2;
    assign out_base2_none = rec.base2_none;
    assign out_disp2      = rec.disp2;
    assign out_len1       = rec.len1;
    assign out_len2       = rec.len2;

    // R11
    hold_rec_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(rec));

    // R11
    stall_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> !in_ready);

    // R7
    ss1_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fmt == 3'd4 |-> out_len1 != 9'd0 && out_len2 == 9'd0);

    // R8
    ss2_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fmt == 3'd5 |->
        out_len1 >= 9'd1 && out_len1 <= 9'd16 && out_len2 >= 9'd1 && out_len2 <= 9'd16);

    // R9
    rr_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fmt == 3'd0 |-> !out_r2_none && !out_base1_none && !out_base2_none);

endmodule

// File: tb/insn_stream_parser_tb.sv
module insn_stream_parser_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_byte = 8'h00;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [2:0] out_fmt;
    logic [7:0] out_opcode, out_imm;
    logic [3:0] out_r1, out_r2, out_base1, out_base2;
    logic out_r2_none, out_base1_none, out_base2_none;
    logic [11:0] out_disp1, out_disp2;
    logic [8:0] out_len1, out_len2;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic early_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_stream_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt), .out_opcode(out_opcode),
        .out_r1(out_r1), .out_r2(out_r2), .out_r2_none(out_r2_none), .out_imm(out_imm),
        .out_base1(out_base1), .out_base1_none(out_base1_none), .out_disp1(out_disp1),
        .out_base2(out_base2), .out_base2_none(out_base2_none), .out_disp2(out_disp2),
        .out_len1(out_len1), .out_len2(out_len2)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] v);
        bit took = 1'b0;
        while (!took) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = v;
            took     = in_ready;
            if (took && out_valid) early_seen = 1'b1;
            @(posedge clk);
        end
    endtask

    // R1 / R12: record due one cycle after final byte, never earlier
    task automatic send_insn(input logic [7:0] b [6], input int n, input int gap);
        early_seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            put_byte(b[i]);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                if (out_valid && i < n - 1) early_seen = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "early out_valid", {31'd0, early_seen}, 32'd0);
        chk("R1", "out_valid after last byte", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic get_rec(input string req, input logic [2:0] f, input logic [7:0] op,
                           input logic [3:0] r1, input logic [3:0] r2, input logic r2n,
                           input logic [7:0] imm, input logic [3:0] b1, input logic b1n,
                           input logic [11:0] d1, input logic [3:0] b2, input logic b2n,
                           input logic [11:0] d2, input logic [8:0] l1, input logic [8:0] l2);
        chk("R2", "fmt", {29'd0, out_fmt}, {29'd0, f});
        chk(req, "opcode", {24'd0, out_opcode}, {24'd0, op});
        chk(req, "r1", {28'd0, out_r1}, {28'd0, r1});
        chk(req, "r2", {28'd0, out_r2}, {28'd0, r2});
        chk(req, "r2_none", {31'd0, out_r2_none}, {31'd0, r2n});
        chk(req, "imm", {24'd0, out_imm}, {24'd0, imm});
        chk(req, "base1", {28'd0, out_base1}, {28'd0, b1});
        chk(req, "base1_none", {31'd0, out_base1_none}, {31'd0, b1n});
        chk(req, "disp1", {20'd0, out_disp1}, {20'd0, d1});
        chk(req, "base2", {28'd0, out_base2}, {28'd0, b2});
        chk(req, "base2_none", {31'd0, out_base2_none}, {31'd0, b2n});
        chk(req, "disp2", {20'd0, out_disp2}, {20'd0, d2});
        chk(req, "len1", {23'd0, out_len1}, {23'd0, l1});
        chk(req, "len2", {23'd0, out_len2}, {23'd0, l2});
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk("R11", "out_valid after pop", {31'd0, out_valid}, 32'd0);
        chk("R11", "in_ready after pop", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_reset_state;
        chk("R13", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R13", "reset in_ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_rr;
        logic [7:0] b [6] = '{8'h1A, 8'h68, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(b, 2, 0);
        get_rec("R3", 3'd0, 8'h1A, 4'h6, 4'h8, 1'b0, 8'h00, 4'h0, 1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
        b = '{8'h07, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(b, 2, 0);
        get_rec("R9", 3'd0, 8'h07, 4'hF, 4'h0, 1'b0, 8'h00, 4'h0, 1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    task automatic t_rs;
        logic [7:0] b [6] = '{8'h89, 8'h60, 8'h00, 8'h0C, 8'h00, 8'h00};
        send_insn(b, 4, 0);
        get_rec("R9", 3'd1, 8'h89, 4'h6, 4'h0, 1'b1, 8'h00, 4'h0, 1'b1, 12'h00C, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    task automatic t_rx;
        logic [7:0] b [6] = '{8'h5E, 8'h47, 8'hC1, 8'h23, 8'h00, 8'h00};
        send_insn(b, 4, 0);
        get_rec("R4", 3'd2, 8'h5E, 4'h4, 4'h7, 1'b0, 8'h00, 4'hC, 1'b0, 12'h123, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
        b = '{8'hA0, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00};
        send_insn(b, 4, 0);
        get_rec("R2", 3'd2, 8'hA0, 4'h1, 4'h2, 1'b0, 8'h00, 4'h3, 1'b0, 12'h456, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    task automatic t_si;
        logic [7:0] b [6] = '{8'h92, 8'h5C, 8'h36, 8'hC4, 8'h00, 8'h00};
        send_insn(b, 4, 0);
        get_rec("R5", 3'd3, 8'h92, 4'h0, 4'h0, 1'b0, 8'h5C, 4'h3, 1'b0, 12'h6C4, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    task automatic t_ss1;
        logic [7:0] b [6] = '{8'hD2, 8'h0D, 8'h34, 8'h0A, 8'h34, 8'h2C};
        send_insn(b, 6, 0);
        get_rec("R6", 3'd4, 8'hD2, 4'h0, 4'h0, 1'b0, 8'h00, 4'h3, 1'b0, 12'h40A, 4'h3, 1'b0, 12'h42C, 9'd14, 9'd0);
        b = '{8'hD5, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01};
        send_insn(b, 6, 0);
        get_rec("R7", 3'd4, 8'hD5, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0, 1'b1, 12'h000, 4'h0, 1'b1, 12'h001, 9'd256, 9'd0);
        b = '{8'hC0, 8'h00, 8'h10, 8'h01, 8'h20, 8'h02};
        send_insn(b, 6, 0);
        get_rec("R7", 3'd4, 8'hC0, 4'h0, 4'h0, 1'b0, 8'h00, 4'h1, 1'b0, 12'h001, 4'h2, 1'b0, 12'h002, 9'd1, 9'd0);
    endtask

    task automatic t_ss2;
        logic [7:0] b [6] = '{8'hFA, 8'h32, 8'h35, 8'h0A, 8'h35, 8'h2C};
        send_insn(b, 6, 0);
        get_rec("R8", 3'd5, 8'hFA, 4'h0, 4'h0, 1'b0, 8'h00, 4'h3, 1'b0, 12'h50A, 4'h3, 1'b0, 12'h52C, 9'd4, 9'd3);
        b = '{8'hF9, 8'hF0, 8'h7F, 8'hFF, 8'h80, 8'h00};
        send_insn(b, 6, 0);
        get_rec("R8", 3'd5, 8'hF9, 4'h0, 4'h0, 1'b0, 8'h00, 4'h7, 1'b0, 12'hFFF, 4'h8, 1'b0, 12'h000, 9'd16, 9'd1);
    endtask

    task automatic t_gaps;
        logic [7:0] b [6] = '{8'hD2, 8'h01, 8'h40, 8'h56, 8'h40, 8'h9F};
        send_insn(b, 6, 3);
        get_rec("R12", 3'd4, 8'hD2, 4'h0, 4'h0, 1'b0, 8'h00, 4'h4, 1'b0, 12'h056, 4'h4, 1'b0, 12'h09F, 9'd2, 9'd0);
    endtask

    task automatic t_backpressure;
        logic [7:0] b [6] = '{8'h5E, 8'h47, 8'hC1, 8'h23, 8'h00, 8'h00};
        send_insn(b, 4, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h1A;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11", "in_ready while held", {31'd0, in_ready}, 32'd0);
            chk("R11", "out_valid while held", {31'd0, out_valid}, 32'd1);
            chk("R11", "opcode while held", {24'd0, out_opcode}, 32'h5E);
        end
        get_rec("R11", 3'd2, 8'h5E, 4'h4, 4'h7, 1'b0, 8'h00, 4'hC, 1'b0, 12'h123, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
        b = '{8'h1A, 8'h68, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(b, 2, 0);
        get_rec("R12", 3'd0, 8'h1A, 4'h6, 4'h8, 1'b0, 8'h00, 4'h0, 1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    task automatic t_reset_mid;
        logic [7:0] b [6] = '{8'h1A, 8'h23, 8'h00, 8'h00, 8'h00, 8'h00};
        put_byte(8'hD2);
        put_byte(8'h0D);
        put_byte(8'h34);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R13", "out_valid after mid reset", {31'd0, out_valid}, 32'd0);
        chk("R13", "in_ready after mid reset", {31'd0, in_ready}, 32'd1);
        send_insn(b, 2, 0);
        get_rec("R13", 3'd0, 8'h1A, 4'h2, 4'h3, 1'b0, 8'h00, 4'h0, 1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 9'd0, 9'd0);
    endtask

    // R10 is covered by the zero expectations for absent fields in every get_rec call
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_rr();
        t_rs();
        t_rx();
        t_si();
        t_ss1();
        t_ss2();
        t_gaps();
        t_backpressure();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog expired got=%0d exp<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule